// File: doc/BRIEF.md
# Prefetch Burst Boundary Limiter

This block decides, beat by beat, whether a burst in progress on a PCI-style bus must end now, and why. A burst is opened with a start pulse that carries the first beat address (counted in beats, one beat per data word) and the burst's attributes: read or write, DMA or not, master side or target side, and the ID of the requester. Every beat strobe then moves the tracked address on by one beat. The block combines three reasons to stop: a read prefetch boundary, a stalled FIFO on the target side, and an expired latency timer on the master side. A done pulse closes the burst.

The boundary is a power of two taken from a limit register given in beats (0x400 beats is a 4 KiB window for 32-bit words). Only reads that are not DMA are bounded. On the master side, a requester whose bit is set in the mask vector is held to a fixed window of 1 KiB (256 beats) whatever the limit register holds. The limit, mask and requester ID are sampled when the burst opens. The terminate request and reason code are combinational outputs of the registered burst state and the live FIFO and timeout inputs, so the bus controller sees them in the same cycle that the condition holds.

Top module: `pbl_limiter`

## Requirements
- R1: After reset, term_o is 0 and reason_o is 0 (none), and no burst is open.
- R2: start_i opens a burst at start_addr_i; every beat_i while a burst is open advances the tracked beat address by one; start_i takes precedence over beat_i and done_i in the same cycle.
- R3: For a bounded read with window L beats, term_o is 1 with reason_o = 1 (boundary disconnect) exactly while the tracked address a satisfies (a+1) mod L = 0, i.e. on the last beat before the aligned boundary.
- R4: A limit value that is not a power of two is rounded down to the highest power of two not above it (12 acts as 8); a limit of 0 disables the boundary.
- R5: For a master-side read whose requester bit is set in req_mask_i, the window is 256 beats regardless of limit_i; an unmasked master read, and any target-side read, uses limit_i.
- R6: A DMA burst never terminates with reason 1.
- R7: A write burst never terminates with reason 1.
- R8: On the target side, fifo_avail_i = 0 during an open burst gives term_o = 1 with reason_o = 2 (FIFO disconnect) in the same cycle; on the master side fifo_avail_i has no effect.
- R9: On the master side, a lat_timeout_i pulse during an open burst gives term_o = 1 with reason_o = 3 (master stop) in the same cycle and holds it until the burst closes or restarts; on the target side the pulse has no effect.
- R10: When several causes hold at once, reason_o picks master stop (3) over boundary (1) over FIFO (2); term_o = 1 always comes with a nonzero reason.
- R11: done_i closes the burst; with no burst open term_o is 0 and reason_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a burst and samples its attributes |
| start_addr_i | input | ADDR_W | First beat address, in beats |
| read_i | input | 1 | 1 for a read burst |
| dma_i | input | 1 | 1 for a DMA burst |
| master_i | input | 1 | 1 for master side, 0 for target side |
| req_id_i | input | ID_W | Requester ID |
| req_mask_i | input | NREQ | Per-requester bit forcing the 256-beat window |
| limit_i | input | LIM_W | Boundary in beats |
| beat_i | input | 1 | One beat transferred |
| done_i | input | 1 | Closes the burst |
| lat_timeout_i | input | 1 | Latency timer expiry pulse |
| fifo_avail_i | input | 1 | A FIFO can take or give data |
| term_o | output | 1 | Burst must end |
| reason_o | output | 2 | 0 none, 1 boundary, 2 FIFO, 3 master stop |

## Verification
The in-design properties watch on every cycle that an idle block stays quiet, that a raised terminate always carries a reason, that FIFO and timeout reasons appear only on their own side, that DMA and write bursts never report a boundary, that a timeout stays latched, and that a boundary hit clears after the crossing beat. Which beat actually hits the boundary for a given window, the rounding of odd limits, the fixed window for masked requesters, and the ordering of reasons when causes coincide can only be shown by the bench's directed bursts against computed addresses.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  typedef enum logic [1:0] {
    RSN_NONE  = 2'd0,
    RSN_BOUND = 2'd1,
    RSN_FIFO  = 2'd2,
    RSN_STOP  = 2'd3
  } rsn_e;
endpackage

// File: rtl/pbl_limit_sel.sv
module pbl_limit_sel #(
  parameter int LIM_W        = 16,
  parameter int NREQ         = 8,
  parameter int ID_W         = 3,
  parameter int MASKED_BEATS = 256
) (
  input  logic             read_i,
  input  logic             dma_i,
  input  logic             master_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic [NREQ-1:0]  req_mask_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             bound_en_o,
  output logic [LIM_W-1:0] bound_mask_o
);
  localparam logic [LIM_W-1:0] FIXED_LIM = LIM_W'(MASKED_BEATS);

  logic             use_fixed;
  logic [LIM_W-1:0] src_lim;

  // masked requesters on the master side get the fixed window
  assign use_fixed = master_i && req_mask_i[req_id_i];
  assign src_lim   = use_fixed ? FIXED_LIM : limit_i;

  // round down to a power of two: highest set bit wins
  always_comb begin
    bound_mask_o = '0;
    for (int i = 0; i < LIM_W; i++) begin
      if (src_lim[i]) bound_mask_o = (LIM_W'(1) << i) - LIM_W'(1);
    end
  end

  assign bound_en_o = read_i && !dma_i && (src_lim != '0);
endmodule

// File: rtl/pbl_burst_ctx.sv
module pbl_burst_ctx (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic read_i,
  input  logic dma_i,
  input  logic master_i,
  input  logic lat_timeout_i,
  output logic active_o,
  output logic read_o,
  output logic dma_o,
  output logic master_o,
  output logic timeout_o
);
  logic to_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      read_o    <= 1'b0;
      dma_o     <= 1'b0;
      master_o  <= 1'b0;
      to_seen_q <= 1'b0;
    end else if (start_i) begin
      active_o  <= 1'b1;
      read_o    <= read_i;
      dma_o     <= dma_i;
      master_o  <= master_i;
      to_seen_q <= 1'b0;
    end else if (done_i) begin
      active_o  <= 1'b0;
      to_seen_q <= 1'b0;
    end else if (active_o && master_o && lat_timeout_i) begin
      to_seen_q <= 1'b1;
    end
  end

  assign timeout_o = active_o && master_o && (lat_timeout_i || to_seen_q);

  AST_TIMEOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !start_i && !done_i) |=> timeout_o); // R9
endmodule

// File: rtl/pbl_addr_track.sv
module pbl_addr_track #(
  parameter int ADDR_W = 30,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              beat_i,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              bound_en_i,
  input  logic [LIM_W-1:0]  bound_mask_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] cur_q;
  logic              en_q;
  logic [LIM_W-1:0]  mask_q;
  logic [LIM_W-1:0]  next_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (start_i) begin
      cur_q  <= start_addr_i;
      en_q   <= bound_en_i;
      mask_q <= bound_mask_i;
    end else if (active_i && beat_i) begin
      cur_q  <= cur_q + ADDR_W'(1);
    end
  end

  // next beat would land on an aligned boundary: this beat is the last
  assign next_low = cur_q[LIM_W-1:0] + LIM_W'(1);
  assign hit_o    = en_q && ((next_low & mask_q) == '0);

  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && mask_q != '0 && active_i && beat_i && !start_i) |=> !hit_o); // R3
endmodule

// File: rtl/pbl_term_arb.sv
module pbl_term_arb
  import pbl_pkg::*;
(
  input  logic active_i,
  input  logic master_i,
  input  logic fifo_avail_i,
  input  logic hit_i,
  input  logic timeout_i,
  output logic term_o,
  output rsn_e reason_o
);
  logic fifo_stall;

  assign fifo_stall = active_i && !master_i && !fifo_avail_i;

  always_comb begin
    reason_o = RSN_NONE;
    if (active_i) begin
      if (timeout_i)       reason_o = RSN_STOP;
      else if (hit_i)      reason_o = RSN_BOUND;
      else if (fifo_stall) reason_o = RSN_FIFO;
    end
  end

  assign term_o = (reason_o != RSN_NONE);
endmodule

// File: rtl/pbl_limiter.sv
module pbl_limiter
  import pbl_pkg::*;
#(
  parameter int ADDR_W       = 30,
  parameter int LIM_W        = 16,
  parameter int NREQ         = 8,
  parameter int MASKED_BEATS = 256,
  localparam int ID_W        = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              read_i,
  input  logic              dma_i,
  input  logic              master_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [NREQ-1:0]   req_mask_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              beat_i,
  input  logic              done_i,
  input  logic              lat_timeout_i,
  input  logic              fifo_avail_i,
  output logic              term_o,
  output logic [1:0]        reason_o
);
  logic             bound_en;
  logic [LIM_W-1:0] bound_mask;
  logic             active, read_q, dma_q, master_q, timeout;
  logic             hit;
  rsn_e             rsn;

  pbl_limit_sel #(
    .LIM_W(LIM_W), .NREQ(NREQ), .ID_W(ID_W), .MASKED_BEATS(MASKED_BEATS)
  ) u_sel (
    .read_i(read_i), .dma_i(dma_i), .master_i(master_i),
    .req_id_i(req_id_i), .req_mask_i(req_mask_i), .limit_i(limit_i),
    .bound_en_o(bound_en), .bound_mask_o(bound_mask)
  );

  pbl_burst_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_i(done_i),
    .read_i(read_i), .dma_i(dma_i), .master_i(master_i),
    .lat_timeout_i(lat_timeout_i),
    .active_o(active), .read_o(read_q), .dma_o(dma_q),
    .master_o(master_q), .timeout_o(timeout)
  );

  pbl_addr_track #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .beat_i(beat_i),
    .active_i(active), .start_addr_i(start_addr_i),
    .bound_en_i(bound_en), .bound_mask_i(bound_mask), .hit_o(hit)
  );

  pbl_term_arb u_arb (
    .active_i(active), .master_i(master_q), .fifo_avail_i(fifo_avail_i),
    .hit_i(hit), .timeout_i(timeout), .term_o(term_o), .reason_o(rsn)
  );

  assign reason_o = rsn;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!term_o && reason_o == 2'd0)); // R11
  AST_TERM_HAS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> (reason_o != 2'd0)); // R10
  AST_FIFO_TARGET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reason_o == 2'd2) |-> (!master_q && !fifo_avail_i)); // R8
  AST_FIFO_STALL_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !master_q && !fifo_avail_i) |-> term_o); // R8
  AST_DMA_UNBOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dma_q) |-> (reason_o != 2'd1)); // R6
  AST_WRITE_UNBOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !read_q) |-> (reason_o != 2'd1)); // R7
  AST_STOP_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reason_o == 2'd3) |-> master_q); // R9
endmodule

// File: tb/pbl_limiter_bench.sv
module pbl_limiter_bench;
  localparam int ADDR_W = 30;
  localparam int LIM_W  = 16;
  localparam int NREQ   = 8;
  localparam int ID_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic              read_i = 1'b0, dma_i = 1'b0, master_i = 1'b0;
  logic [ID_W-1:0]   req_id_i = '0;
  logic [NREQ-1:0]   req_mask_i = 8'b0000_1000;
  logic [LIM_W-1:0]  limit_i = '0;
  logic              beat_i = 1'b0, done_i = 1'b0;
  logic              lat_timeout_i = 1'b0, fifo_avail_i = 1'b1;
  logic              term_o;
  logic [1:0]        reason_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pbl_limiter u_pbl_limiter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .read_i(read_i), .dma_i(dma_i), .master_i(master_i), .req_id_i(req_id_i),
    .req_mask_i(req_mask_i), .limit_i(limit_i), .beat_i(beat_i),
    .done_i(done_i), .lat_timeout_i(lat_timeout_i),
    .fifo_avail_i(fifo_avail_i), .term_o(term_o), .reason_o(reason_o)
  );

  task automatic check(string req, logic t_exp, logic [1:0] r_exp);
    checks++;
    if (term_o !== t_exp || reason_o !== r_exp) begin
      errors++;
      $display("FAIL %s: term=%0b reason=%0d, expected term=%0b reason=%0d",
               req, term_o, reason_o, t_exp, r_exp);
    end
  endtask

  task automatic open_burst(int addr, logic rd, logic dm, logic ms, int id, int lim);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = ADDR_W'(addr); read_i = rd; dma_i = dm;
    master_i = ms; req_id_i = ID_W'(id); limit_i = LIM_W'(lim);
    @(negedge clk);
    start_i = 1'b0;
    #1;
  endtask

  task automatic close_burst();
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk); beat_i = 1'b1;
    @(negedge clk); beat_i = 1'b0;
    #1;
  endtask

  // walk n beats from base; a boundary hit is expected where (a+1) mod L == 0
  task automatic walk(string req, int base, int n, int win, logic bounded);
    for (int k = 0; k < n; k++) begin
      int a = base + k;
      logic h = bounded && (win > 0) && (((a + 1) % win) == 0);
      check(req, h, h ? 2'd1 : 2'd0);
      if (k != n - 1) step();
    end
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0, 2'd0);
  endtask

  task automatic t_boundary();
    open_burst(32'h3FC, 1, 0, 0, 0, 32'h400);
    walk("R3 R2 4KiB window", 32'h3FC, 6, 32'h400, 1'b1);
    close_burst();
    open_burst(32'h7FF, 1, 0, 0, 0, 32'h400);
    check("R3 start on last beat", 1'b1, 2'd1);
    close_burst();
  endtask

  task automatic t_round();
    open_burst(5, 1, 0, 0, 0, 12);
    walk("R4 limit 12 rounds to 8", 5, 5, 8, 1'b1);
    close_burst();
    open_burst(32'h3FE, 1, 0, 0, 0, 0);
    walk("R4 zero limit unbounded", 32'h3FE, 4, 1, 1'b0);
    close_burst();
  endtask

  task automatic t_mask();
    open_burst(32'hFE, 1, 0, 1, 3, 32'h400);
    walk("R5 masked master fixed 256", 32'hFE, 4, 256, 1'b1);
    close_burst();
    open_burst(32'hFE, 1, 0, 1, 2, 32'h400);
    walk("R5 unmasked master uses register", 32'hFE, 4, 32'h400, 1'b1);
    close_burst();
    open_burst(32'hFE, 1, 0, 0, 3, 32'h400);
    walk("R5 target ignores mask", 32'hFE, 4, 32'h400, 1'b1);
    close_burst();
  endtask

  task automatic t_dma_write();
    open_burst(6, 1, 1, 0, 0, 8);
    walk("R6 dma read unbounded", 6, 4, 8, 1'b0);
    close_burst();
    open_burst(6, 1, 1, 1, 3, 8);
    walk("R6 dma masked master unbounded", 6, 3, 8, 1'b0);
    close_burst();
    open_burst(6, 0, 0, 0, 0, 8);
    walk("R7 write unbounded", 6, 4, 8, 1'b0);
    close_burst();
  endtask

  task automatic t_fifo();
    open_burst(0, 1, 0, 0, 0, 32'h400);
    @(negedge clk); fifo_avail_i = 1'b0; #1;
    check("R8 target fifo stall", 1'b1, 2'd2);
    @(negedge clk); fifo_avail_i = 1'b1; #1;
    check("R8 target fifo back", 1'b0, 2'd0);
    close_burst();
    open_burst(0, 0, 0, 1, 0, 32'h400);
    @(negedge clk); fifo_avail_i = 1'b0; #1;
    check("R8 master ignores fifo", 1'b0, 2'd0);
    @(negedge clk); fifo_avail_i = 1'b1; #1;
    close_burst();
  endtask

  task automatic t_timeout();
    open_burst(0, 1, 0, 1, 0, 0);
    @(negedge clk); lat_timeout_i = 1'b1; #1;
    check("R9 timeout same cycle", 1'b1, 2'd3);
    @(negedge clk); lat_timeout_i = 1'b0; #1;
    check("R9 timeout held", 1'b1, 2'd3);
    step();
    check("R9 timeout held after beat", 1'b1, 2'd3);
    close_burst();
    check("R11 closed after timeout", 1'b0, 2'd0);
    open_burst(0, 1, 0, 0, 0, 0);
    @(negedge clk); lat_timeout_i = 1'b1; #1;
    check("R9 target ignores timeout", 1'b0, 2'd0);
    @(negedge clk); lat_timeout_i = 1'b0; #1;
    check("R9 target ignores timeout after", 1'b0, 2'd0);
    close_burst();
  endtask

  task automatic t_priority();
    open_burst(32'hFF, 1, 0, 1, 3, 0);
    check("R10 boundary alone", 1'b1, 2'd1);
    @(negedge clk); lat_timeout_i = 1'b1; #1;
    check("R10 stop over boundary", 1'b1, 2'd3);
    @(negedge clk); lat_timeout_i = 1'b0;
    close_burst();
    open_burst(7, 1, 0, 0, 0, 8);
    @(negedge clk); fifo_avail_i = 1'b0; #1;
    check("R10 boundary over fifo", 1'b1, 2'd1);
    step();
    check("R10 fifo after boundary passed", 1'b1, 2'd2);
    @(negedge clk); fifo_avail_i = 1'b1;
    close_burst();
  endtask

  task automatic t_done();
    open_burst(0, 1, 0, 0, 0, 32'h400);
    @(negedge clk); fifo_avail_i = 1'b0; #1;
    check("R8 stall before close", 1'b1, 2'd2);
    close_burst();
    check("R11 idle while fifo empty", 1'b0, 2'd0);
    @(negedge clk); fifo_avail_i = 1'b1;
    // start and done together: start wins, restart at new address
    @(negedge clk);
    start_i = 1'b1; done_i = 1'b1; start_addr_i = ADDR_W'(7);
    read_i = 1'b1; dma_i = 1'b0; master_i = 1'b0; limit_i = LIM_W'(8);
    @(negedge clk); start_i = 1'b0; done_i = 1'b0; #1;
    check("R2 start beats done", 1'b1, 2'd1);
    close_burst();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    #1;
    t_reset();
    t_boundary();
    t_round();
    t_mask();
    t_dma_write();
    t_fifo();
    t_timeout();
    t_priority();
    t_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule